// File: doc/BRIEF.md
# Two-Port Memory with Doorbell Interrupts

This block is a two-port word memory. Each port, called left and right, can read and write any location independently. It also carries a pair of port-to-port doorbell interrupts. The two highest addresses are reserved as mailboxes, one owned by each port:

- The right port's mailbox is the very top address. When the left port writes it, the right port's interrupt goes low. When the right port reads it, the interrupt returns high.
- The left port's mailbox is the address just below the top. It works the same way with the roles of the ports swapped.

Both mailbox words remain ordinary storage, and software decides what they mean. A typical use is to leave a message in the other side's mailbox, which rings its doorbell. The receiver reads the same word, which returns the message and acknowledges the doorbell.

The depth is a parameter. With a 13-bit address the mailboxes sit at 0x1FFF (right) and 0x1FFE (left). The default build uses a 10-bit address, so the mailboxes sit at 1023 (right) and 1022 (left).

All controls are active low and sampled on the rising clock edge. A port performs an access only when it is selected:

- With the write strobe low, the access is a write.
- With the write strobe high and the output enable low, the access is a read.
- In every other state the port is idle.

Top module: `dpmb_mailbox`

## Requirements
- R1: While reset is held and in the first cycle after it, both interrupt outputs are high and both read-data outputs are zero.
- R2: A write stores the word at the addressed location on the clock edge. A read returns that location's contents on the read-data output after the next clock edge, and the two ports share one storage array.
- R3: A port's read-data output holds its last value in every cycle in which that port does not read.
- R4: A left-port write to the top address drives the right interrupt low after that clock edge.
- R5: A right-port read of the top address drives the right interrupt high after that clock edge.
- R6: A right-port write to the top address minus one drives the left interrupt low after that clock edge.
- R7: A left-port read of the top address minus one drives the left interrupt high after that clock edge.
- R8: Both mailbox addresses store and return written data like any other word.
- R9: When a set and a clear of the same interrupt fall in the same cycle, the interrupt ends low.
- R10: A port writing its own mailbox, or reading the other port's mailbox, leaves both interrupts unchanged.
- R11: A port that is not selected does not write. A selected port with both the write strobe and the output enable high neither reads nor clears an interrupt.
- R12: When both ports write the same address in one cycle, the right port's word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| lSelN | input | 1 | Left port select, active low |
| lWeN | input | 1 | Left write strobe, low = write, high = read |
| lOeN | input | 1 | Left output enable, active low, needed for reads |
| lAddr | input | ADDR_W | Left word address |
| lWrData | input | DATA_W | Left write data |
| lRdData | output | DATA_W | Left read data, registered |
| lIrqN | output | 1 | Left doorbell interrupt, active low |
| rSelN | input | 1 | Right port select, active low |
| rWeN | input | 1 | Right write strobe, low = write, high = read |
| rOeN | input | 1 | Right output enable, active low, needed for reads |
| rAddr | input | ADDR_W | Right word address |
| rWrData | input | DATA_W | Right write data |
| rRdData | output | DATA_W | Right read data, registered |
| rIrqN | output | 1 | Right doorbell interrupt, active low |

## Verification
Each interrupt flag is one register, so a wrong flag state shows on that port's interrupt output one cycle after the access that caused it, and it stays wrong until a legal set or clear corrects it. A mis-decoded mailbox address shows up as a doorbell that never rings or never clears, or as a flag that moves after an access to the wrong mailbox. Storage or read-path faults show on read data exactly one cycle after a read. A missed hold shows as read data that changes during idle cycles.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

  localparam int NumPorts = 2;
  localparam int PortL = 0;
  localparam int PortR = 1;

  // Strobes decoded by the control and consumed by the datapath.
  typedef struct packed {
    logic [NumPorts-1:0] wrEn;
    logic [NumPorts-1:0] rdEn;
    logic [NumPorts-1:0] irqSet;   // index = port whose interrupt is raised
    logic [NumPorts-1:0] irqClr;   // index = port whose interrupt is dropped
  } dpmb_strobe_t;

endpackage

// File: rtl/dpmb_ctrl.sv
module dpmb_ctrl
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [NumPorts-1:0]             selN,
  input  logic [NumPorts-1:0]             weN,
  input  logic [NumPorts-1:0]             oeN,
  input  logic [NumPorts-1:0][ADDR_W-1:0] addr,
  output dpmb_strobe_t                    strobe
);

  // Mailbox owned by each port: right owns the top word, left the one below.
  localparam logic [ADDR_W-1:0] TopAddr = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MboxL   = TopAddr - 1'b1;
  localparam logic [ADDR_W-1:0] MboxR   = TopAddr;

  logic [NumPorts-1:0] isWr;
  logic [NumPorts-1:0] isRd;
  logic [NumPorts-1:0] hitOwn;    // port addresses its own mailbox
  logic [NumPorts-1:0] hitOther;  // port addresses the other port's mailbox

  for (genvar p = 0; p < NumPorts; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OwnBox   = (p == PortL) ? MboxL : MboxR;
    localparam logic [ADDR_W-1:0] OtherBox = (p == PortL) ? MboxR : MboxL;

    always_comb begin
      isWr[p]     = !selN[p] && !weN[p];
      isRd[p]     = !selN[p] &&  weN[p] && !oeN[p];
      hitOwn[p]   = (addr[p] == OwnBox);
      hitOther[p] = (addr[p] == OtherBox);
    end
  end

  always_comb begin
    strobe.wrEn           = isWr;
    strobe.rdEn           = isRd;
    // A write to the other port's mailbox rings that port's doorbell.
    strobe.irqSet[PortL]  = isWr[PortR] && hitOther[PortR];
    strobe.irqSet[PortR]  = isWr[PortL] && hitOther[PortL];
    // A read of a port's own mailbox acknowledges its doorbell.
    strobe.irqClr[PortL]  = isRd[PortL] && hitOwn[PortL];
    strobe.irqClr[PortR]  = isRd[PortR] && hitOwn[PortR];
  end

endmodule

// File: rtl/dpmb_doorbell.sv
module dpmb_doorbell (
  input  logic clk,
  input  logic rstN,
  input  logic setReq,
  input  logic clrReq,
  output logic irqN
);

  // Set has priority over a clear landing in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)       irqN <= 1'b1;
    else if (setReq) irqN <= 1'b0;
    else if (clrReq) irqN <= 1'b1;
  end

endmodule

// File: rtl/dpmb_datapath.sv
module dpmb_datapath
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dpmb_strobe_t                    strobe,
  input  logic [NumPorts-1:0][ADDR_W-1:0] addr,
  input  logic [NumPorts-1:0][DATA_W-1:0] wrData,
  output logic [NumPorts-1:0][DATA_W-1:0] rdData,
  output logic [NumPorts-1:0]             irqN
);

  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [Depth];

  // Left is applied first, right second: right wins a same-address collision.
  always_ff @(posedge clk) begin
    if (strobe.wrEn[PortL]) mem[addr[PortL]] <= wrData[PortL];
    if (strobe.wrEn[PortR]) mem[addr[PortR]] <= wrData[PortR];
  end

  for (genvar p = 0; p < NumPorts; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN)               rdData[p] <= '0;
      else if (strobe.rdEn[p]) rdData[p] <= mem[addr[p]];
    end

    dpmb_doorbell bell_i (
      .clk    (clk),
      .rstN   (rstN),
      .setReq (strobe.irqSet[p]),
      .clrReq (strobe.irqClr[p]),
      .irqN   (irqN[p])
    );
  end

endmodule

// File: rtl/dpmb_mailbox.sv
module dpmb_mailbox
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lSelN,
  input  logic              lWeN,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lIrqN,
  input  logic              rSelN,
  input  logic              rWeN,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData,
  output logic              rIrqN
);

  dpmb_strobe_t                    strobe;
  logic [NumPorts-1:0][ADDR_W-1:0] addrVec;
  logic [NumPorts-1:0][DATA_W-1:0] wrVec;
  logic [NumPorts-1:0][DATA_W-1:0] rdVec;
  logic [NumPorts-1:0]             irqVec;

  assign addrVec = {rAddr, lAddr};
  assign wrVec   = {rWrData, lWrData};
  assign lRdData = rdVec[PortL];
  assign rRdData = rdVec[PortR];
  assign lIrqN   = irqVec[PortL];
  assign rIrqN   = irqVec[PortR];

  dpmb_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .selN   ({rSelN, lSelN}),
    .weN    ({rWeN, lWeN}),
    .oeN    ({rOeN, lOeN}),
    .addr   (addrVec),
    .strobe (strobe)
  );

  dpmb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .addr   (addrVec),
    .wrData (wrVec),
    .rdData (rdVec),
    .irqN   (irqVec)
  );

endmodule

// File: rtl/dpmb_checker.sv
module dpmb_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              lSelN,
  input logic              lWeN,
  input logic              lOeN,
  input logic [ADDR_W-1:0] lAddr,
  input logic [DATA_W-1:0] lRdData,
  input logic              lIrqN,
  input logic              rSelN,
  input logic              rWeN,
  input logic              rOeN,
  input logic [ADDR_W-1:0] rAddr,
  input logic [DATA_W-1:0] rRdData,
  input logic              rIrqN
);

  localparam logic [ADDR_W-1:0] TopA = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NextA = TopA - 1'b1;

  logic lWr, lRd, rWr, rRd;
  assign lWr = !lSelN && !lWeN;
  assign lRd = !lSelN && lWeN && !lOeN;
  assign rWr = !rSelN && !rWeN;
  assign rRd = !rSelN && rWeN && !rOeN;

  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (lIrqN && rIrqN && lRdData == '0 && rRdData == '0));

  a_r3_left_hold: assert property (@(posedge clk) disable iff (!rstN)
    !lRd |=> $stable(lRdData));

  a_r3_right_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rRd |=> $stable(rRdData));

  a_r4_right_set: assert property (@(posedge clk) disable iff (!rstN)
    (lWr && lAddr == TopA) |=> !rIrqN);

  a_r6_left_set: assert property (@(posedge clk) disable iff (!rstN)
    (rWr && rAddr == NextA) |=> !lIrqN);

  a_r5_right_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rRd && rAddr == TopA && !(lWr && lAddr == TopA)) |=> rIrqN);

  a_r7_left_clear: assert property (@(posedge clk) disable iff (!rstN)
    (lRd && lAddr == NextA && !(rWr && rAddr == NextA)) |=> lIrqN);

  a_r10_right_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rIrqN) |-> $past(lWr && lAddr == TopA));

  a_r10_right_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rIrqN) |-> $past(rRd && rAddr == TopA));

  a_r10_left_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lIrqN) |-> $past(rWr && rAddr == NextA));

  a_r10_left_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lIrqN) |-> $past(lRd && lAddr == NextA));

endmodule

bind dpmb_mailbox dpmb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .lSelN   (lSelN),
  .lWeN    (lWeN),
  .lOeN    (lOeN),
  .lAddr   (lAddr),
  .lRdData (lRdData),
  .lIrqN   (lIrqN),
  .rSelN   (rSelN),
  .rWeN    (rWeN),
  .rOeN    (rOeN),
  .rAddr   (rAddr),
  .rRdData (rRdData),
  .rIrqN   (rIrqN)
);

// File: tb/dpmb_mailbox_tb.sv
module dpmb_mailbox_tb_top;

  localparam int AW = 10;
  localparam int DW = 8;
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = TOP - 1'b1;

  logic clk = 1'b0;
  logic rstN;
  logic lSelN, lWeN, lOeN, rSelN, rWeN, rOeN;
  logic [AW-1:0] lAddr, rAddr;
  logic [DW-1:0] lWrData, rWrData, lRdData, rRdData;
  logic lIrqN, rIrqN;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dpmb_mailbox #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN),
    .lSelN(lSelN), .lWeN(lWeN), .lOeN(lOeN), .lAddr(lAddr),
    .lWrData(lWrData), .lRdData(lRdData), .lIrqN(lIrqN),
    .rSelN(rSelN), .rWeN(rWeN), .rOeN(rOeN), .rAddr(rAddr),
    .rWrData(rWrData), .rRdData(rRdData), .rIrqN(rIrqN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Port drive: kind 0 idle, 1 write, 2 read, 3 selected with no strobe, 4 unselected write
  task automatic driveL(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d);
    lAddr = a; lWrData = d;
    lSelN = (kind == 0 || kind == 4);
    lWeN  = !(kind == 1 || kind == 4);
    lOeN  = (kind != 2);
  endtask

  task automatic driveR(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d);
    rAddr = a; rWrData = d;
    rSelN = (kind == 0 || kind == 4);
    rWeN  = !(kind == 1 || kind == 4);
    rOeN  = (kind != 2);
  endtask

  // Inputs change on falling edges; after tick the edge's results are visible.
  task automatic tick();
    @(negedge clk);
    driveL(0, '0, '0);
    driveR(0, '0, '0);
  endtask

  task automatic t_reset();
    check("R1 lIrqN", lIrqN, 1);
    check("R1 rIrqN", rIrqN, 1);
    check("R1 lRdData", lRdData, 0);
    check("R1 rRdData", rRdData, 0);
  endtask

  task automatic t_basic();
    driveL(1, 5, 8'hA5); tick();
    driveR(2, 5, 0); tick();
    check("R2 right reads left write", rRdData, 8'hA5);
    driveR(1, 7, 8'h3C); tick();
    driveL(2, 7, 0); tick();
    check("R2 left reads right write", lRdData, 8'h3C);
    tick(); tick();
    check("R3 left hold idle", lRdData, 8'h3C);
    check("R3 right hold idle", rRdData, 8'hA5);
    driveL(3, 5, 0); tick();
    check("R11 no read without oe", lRdData, 8'h3C);
    driveL(4, 5, 8'hFF); tick();
    driveR(2, 5, 0); tick();
    check("R11 unselected no write", rRdData, 8'hA5);
  endtask

  task automatic t_rightBell();
    driveL(1, TOP, 8'h77); tick();
    check("R4 right irq set", rIrqN, 0);
    check("R4 left irq untouched", lIrqN, 1);
    driveL(2, TOP, 0); tick();
    check("R8 top word stored", lRdData, 8'h77);
    check("R10 other mailbox read keeps right irq", rIrqN, 0);
    driveR(1, TOP, 8'h11); tick();
    check("R10 own mailbox write keeps right irq", rIrqN, 0);
    driveR(3, TOP, 0); tick();
    check("R11 no clear without oe", rIrqN, 0);
    driveR(2, TOP, 0); tick();
    check("R5 right irq cleared", rIrqN, 1);
    check("R8 right reads own mailbox", rRdData, 8'h11);
  endtask

  task automatic t_leftBell();
    driveR(1, NEXT, 8'h5A); tick();
    check("R6 left irq set", lIrqN, 0);
    check("R6 right irq untouched", rIrqN, 1);
    driveR(2, NEXT, 0); tick();
    check("R10 other mailbox read keeps left irq", lIrqN, 0);
    check("R8 next word stored", rRdData, 8'h5A);
    driveL(1, NEXT, 8'h99); tick();
    check("R10 own mailbox write keeps left irq", lIrqN, 0);
    driveL(2, NEXT, 0); tick();
    check("R7 left irq cleared", lIrqN, 1);
    check("R8 left reads own mailbox", lRdData, 8'h99);
  endtask

  task automatic t_priority();
    driveL(1, TOP, 8'h21); driveR(2, TOP, 0); tick();
    check("R9 right set wins over clear", rIrqN, 0);
    driveR(1, NEXT, 8'h31); driveL(2, NEXT, 0); tick();
    check("R9 left set wins over clear", lIrqN, 0);
    driveR(2, TOP, 0); driveL(2, NEXT, 0); tick();
    check("R5 right cleared after tie", rIrqN, 1);
    check("R7 left cleared after tie", lIrqN, 1);
  endtask

  task automatic t_collide();
    driveL(1, 9, 8'h01); driveR(1, 9, 8'h02); tick();
    driveL(2, 9, 0); tick();
    check("R12 right wins collision", lRdData, 8'h02);
  endtask

  initial begin
    driveL(0, '0, '0);
    driveR(0, '0, '0);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_rightBell();
    t_leftBell();
    t_priority();
    t_collide();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule